// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block produces the chip-enable, read-strobe and write-strobe waveforms for a single data, command or address cycle on a NAND flash bus. It also drives the command-latch and address-latch lines. A controller pulses `start` while the block is idle and supplies the access kind, a packed timing word and a flag. The flag marks the access as one that launches a device operation, such as the final byte of a program or read command. The block then walks through its phases: an optional turnaround gap, chip-enable setup, strobe low and strobe high. It raises `capture` in the cycle a read strobe returns high and pulses `done` when the high phase is over.

Every phase length is measured in controller clocks. Each length is taken from its own field of the timing word, and a field value of zero counts as one clock. The word is taken in when the access begins, so software can rewrite it at any time without corrupting the access in flight. For an access that launches a device operation, the block ignores the ready/busy line for a programmable number of clocks. It then waits for the line to read ready before it returns to idle.

Top module: `nand_strobe_gen`

## Requirements
- R1: After a synchronous reset, `nce_n`, `nre_n` and `nwe_n` are 1, `cle`, `ale`, `capture` and `done` are 0 and `idle` is 1.
- R2: `acc_type` encodes 0 = read, 1 = write, 2 = command, 3 = address. A read pulses `nre_n` only. The other three kinds pulse `nwe_n` only. `cle` is high for a command and `ale` is high for an address, in both cases for every cycle in which `nce_n` is low.
- R3: `nce_n` goes low in the cycle after `start` is taken, or after the turnaround gap. The strobe falls after the number of clocks in the chip-enable field, bits 25:24.
- R4: A write-class strobe stays low for the count in bits 3:0 and high for the count in bits 7:4. A read strobe stays low for the count in bits 11:8 and high for the count in bits 15:12.
- R5: Any field holding zero acts as one clock.
- R6: `capture` is high for exactly one cycle, the cycle in which `nre_n` returns high. It is never raised for write-class accesses.
- R7: `done` is high for one cycle, immediately after the high phase. In that same cycle `nce_n` is high again.
- R8: When a read follows a write-class access, or the reverse, `nce_n` stays high for the turnaround count in bits 18:16 before setup begins. There is no gap between accesses in the same direction, and none before the first access after reset.
- R9: When `op_launch` is set with `start`, `rdy_busy` is ignored for the count in bits 23:19 after `done`. The block then waits for `rdy_busy` = 1 before `idle` returns.
- R10: A `start` that arrives while `idle` is 0 is ignored. It does not change the waveform or the direction used for the next turnaround decision.
- R11: The timing word is sampled in the cycle `start` is accepted. Later changes have no effect on the access in flight.
- R12: `nre_n` and `nwe_n` are never low together, and neither is low while `nce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an access; accepted only while idle |
| acc_type | input | 2 | 0 read, 1 write, 2 command, 3 address |
| op_launch | input | 1 | Access launches a device operation; do the busy wait afterwards |
| timing_word | input | 26 | Packed phase lengths in clocks |
| rdy_busy | input | 1 | Device ready (1) / busy (0) |
| nce_n | output | 1 | Chip enable, active low |
| nre_n | output | 1 | Read strobe, active low |
| nwe_n | output | 1 | Write strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| capture | output | 1 | Read data capture pulse |
| done | output | 1 | Access-complete pulse |
| idle | output | 1 | Block can accept `start` |

## Verification
All outputs are registered. If `start` is seen at clock edge 0 and the access has gap g, setup c, low l and high h, then `nce_n` falls in cycle g. The strobe falls in cycle g+c, `capture` lands in cycle g+c+l, and `done` and the returning `idle` land in cycle g+c+l+h. With a launch flag, `idle` returns in cycle g+c+l+h+b+1 while ready is held high. The bench records every output once per cycle at the falling edge, starting in the cycle after `start` is taken. It compares each whole trace with a waveform it builds from the field values, so an output that is early or late by one cycle is reported with the cycle where it first differs. For the case where ready is held low, it raises the line and checks that `idle` returns one falling edge later.

// File: rtl/nsg_pkg.sv
package nsg_pkg;
  localparam int CNT_W = 5;
  localparam int NF    = 7;
  localparam int WORD_W = 26;

  localparam int F_WL = 0;
  localparam int F_WH = 1;
  localparam int F_RL = 2;
  localparam int F_RH = 3;
  localparam int F_TA = 4;
  localparam int F_BD = 5;
  localparam int F_CE = 6;

  localparam int FLD_LSB [NF] = '{0, 4, 8, 12, 16, 19, 24};
  localparam int FLD_W   [NF] = '{4, 4, 4, 4, 3, 5, 2};

  typedef logic [NF-1:0][CNT_W-1:0] len_vec_t;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_CMD   = 2'd2,
    ACC_ADDR  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_SETUP, ST_LOW, ST_HIGH, ST_BUSY, ST_WAIT
  } st_e;

  function automatic logic [CNT_W-1:0] less_one(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction
endpackage

// File: rtl/nsg_word_decode.sv
module nsg_word_decode
  import nsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] word_in,
  output len_vec_t          len
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_sel;

  always_ff @(posedge clk) begin
    if (rst) word_q <= '0;
    else if (take) word_q <= word_in;
  end

  // While idle the live word feeds the first phase load; afterwards the frozen copy.
  assign word_sel = take ? word_in : word_q;

  for (genvar g = 0; g < NF; g++) begin : g_field
    localparam int LSB = FLD_LSB[g];
    localparam int W   = FLD_W[g];
    logic [CNT_W-1:0] raw;
    assign raw    = CNT_W'(word_sel[LSB +: W]);
    assign len[g] = (raw == '0) ? CNT_W'(1) : raw;
  end
endmodule

// File: rtl/nsg_phase_cnt.sv
module nsg_phase_cnt #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/nsg_ctrl.sv
module nsg_ctrl
  import nsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       acc_type,
  input  logic             op_launch,
  input  logic             rdy_busy,
  input  len_vec_t         len,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [CNT_W-1:0] cnt_val,
  output logic             word_take,
  output logic             nce_n,
  output logic             nre_n,
  output logic             nwe_n,
  output logic             cle,
  output logic             ale,
  output logic             capture,
  output logic             done,
  output logic             idle
);
  st_e  st_q, st_d;
  acc_e type_q, type_nx;
  logic launch_q, seen_q, last_rd_q;
  logic take_start, in_rd, act_d;

  assign take_start = (st_q == ST_IDLE) && start;
  assign in_rd      = (acc_e'(acc_type) == ACC_READ);
  assign type_nx    = take_start ? acc_e'(acc_type) : type_q;
  assign word_take  = (st_q == ST_IDLE);

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        cnt_load = 1'b1;
        if (seen_q && (last_rd_q != in_rd)) begin
          st_d    = ST_GAP;
          cnt_val = less_one(len[F_TA]);
        end else begin
          st_d    = ST_SETUP;
          cnt_val = less_one(len[F_CE]);
        end
      end
      ST_GAP: if (cnt_zero) begin
        st_d = ST_SETUP; cnt_load = 1'b1; cnt_val = less_one(len[F_CE]);
      end
      ST_SETUP: if (cnt_zero) begin
        st_d = ST_LOW; cnt_load = 1'b1;
        cnt_val = less_one((type_q == ACC_READ) ? len[F_RL] : len[F_WL]);
      end
      ST_LOW: if (cnt_zero) begin
        st_d = ST_HIGH; cnt_load = 1'b1;
        cnt_val = less_one((type_q == ACC_READ) ? len[F_RH] : len[F_WH]);
      end
      ST_HIGH: if (cnt_zero) begin
        if (launch_q) begin
          st_d = ST_BUSY; cnt_load = 1'b1; cnt_val = less_one(len[F_BD]);
        end else begin
          st_d = ST_IDLE;
        end
      end
      ST_BUSY: if (cnt_zero) st_d = ST_WAIT;
      ST_WAIT: if (rdy_busy) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign act_d = (st_d == ST_SETUP) || (st_d == ST_LOW) || (st_d == ST_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      type_q    <= ACC_READ;
      launch_q  <= 1'b0;
      seen_q    <= 1'b0;
      last_rd_q <= 1'b0;
      nce_n     <= 1'b1;
      nre_n     <= 1'b1;
      nwe_n     <= 1'b1;
      cle       <= 1'b0;
      ale       <= 1'b0;
      capture   <= 1'b0;
      done      <= 1'b0;
      idle      <= 1'b1;
    end else begin
      st_q <= st_d;
      if (take_start) begin
        type_q    <= acc_e'(acc_type);
        launch_q  <= op_launch;
        seen_q    <= 1'b1;
        last_rd_q <= in_rd;
      end
      nce_n   <= !act_d;
      nre_n   <= !((st_d == ST_LOW) && (type_nx == ACC_READ));
      nwe_n   <= !((st_d == ST_LOW) && (type_nx != ACC_READ));
      cle     <= act_d && (type_nx == ACC_CMD);
      ale     <= act_d && (type_nx == ACC_ADDR);
      capture <= (st_q == ST_LOW) && cnt_zero && (type_q == ACC_READ);
      done    <= (st_q == ST_HIGH) && cnt_zero;
      idle    <= (st_d == ST_IDLE);
    end
  end

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(!nre_n && !nwe_n));
  assert_strobe_in_ce_R12: assert property (@(posedge clk) disable iff (rst)
    (!nre_n || !nwe_n) |-> !nce_n);
  assert_capture_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
    capture |-> $rose(nre_n));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_releases_ce_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> nce_n);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    (!idle && start) |=> (type_q == $past(type_q)));
  assert_busy_not_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY) |-> !idle);
endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nsg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        acc_type,
  input  logic              op_launch,
  input  logic [WORD_W-1:0] timing_word,
  input  logic              rdy_busy,
  output logic              nce_n,
  output logic              nre_n,
  output logic              nwe_n,
  output logic              cle,
  output logic              ale,
  output logic              capture,
  output logic              done,
  output logic              idle
);
  len_vec_t         len;
  logic             word_take;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  nsg_word_decode u_dec (
    .clk(clk), .rst(rst), .take(word_take), .word_in(timing_word), .len(len)
  );

  nsg_phase_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_val), .zero(cnt_zero)
  );

  nsg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .acc_type(acc_type),
    .op_launch(op_launch), .rdy_busy(rdy_busy), .len(len),
    .cnt_zero(cnt_zero), .cnt_load(cnt_load), .cnt_val(cnt_val),
    .word_take(word_take), .nce_n(nce_n), .nre_n(nre_n), .nwe_n(nwe_n),
    .cle(cle), .ale(ale), .capture(capture), .done(done), .idle(idle)
  );
endmodule

// File: tb/sim_nand_strobe_gen.sv
`timescale 1ns/1ps
module sim_nand_strobe_gen;
  localparam int TR = 64;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, op_launch = 1'b0, rdy_busy = 1'b1;
  logic [1:0]  acc_type = 2'd0;
  logic [25:0] timing_word = '0;
  logic nce_n, nre_n, nwe_n, cle, ale, capture, done, idle;

  int checks = 0, errors = 0;
  bit have_prev = 1'b0, prev_rd = 1'b0, finished = 1'b0;
  logic [TR-1:0] t_nce, t_nre, t_nwe, t_cle, t_ale, t_cap, t_done, t_idle;
  logic [TR-1:0] e_nce, e_nre, e_nwe, e_cle, e_ale, e_cap, e_done, e_idle;

  always #2 clk = ~clk;

  nand_strobe_gen u0 (
    .clk(clk), .rst(rst), .start(start), .acc_type(acc_type),
    .op_launch(op_launch), .timing_word(timing_word), .rdy_busy(rdy_busy),
    .nce_n(nce_n), .nre_n(nre_n), .nwe_n(nwe_n), .cle(cle), .ale(ale),
    .capture(capture), .done(done), .idle(idle)
  );

  function automatic logic [25:0] mk(int wl, int wh, int rl, int rh, int ta, int bd, int ce);
    return {2'(ce), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endfunction

  function automatic int len_of(logic [25:0] w, int lsb, int wd);
    int v;
    v = int'((w >> lsb) & ((26'd1 << wd) - 26'd1));
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(string req, string what, logic [TR-1:0] act, logic [TR-1:0] exp);
    int first;
    checks++;
    if (act !== exp) begin
      errors++;
      first = -1;
      for (int i = TR - 1; i >= 0; i--) if (act[i] !== exp[i]) first = i;
      $display("FAIL %s %s: actual %h expected %h (first cycle %0d)", req, what, act, exp, first);
    end
  endtask

  task automatic chk1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // One access; traces sampled at each falling edge, index 0 = cycle after start is taken.
  task automatic run_access(string req, logic [1:0] ty, logic [25:0] tw,
                            bit launch, bit rdy_lvl, bit disturb);
    int ce, lo, hi, ta, bd, g, fin;
    bit rd, act, lowph;
    rd  = (ty == 2'd0);
    ce  = len_of(tw, 24, 2);
    lo  = rd ? len_of(tw, 8, 4)  : len_of(tw, 0, 4);
    hi  = rd ? len_of(tw, 12, 4) : len_of(tw, 4, 4);
    ta  = len_of(tw, 16, 3);
    bd  = len_of(tw, 19, 5);
    g   = (have_prev && (prev_rd != rd)) ? ta : 0;
    fin = g + ce + lo + hi;
    have_prev = 1'b1;
    prev_rd   = rd;
    @(negedge clk);
    start = 1'b1; acc_type = ty; timing_word = tw; op_launch = launch; rdy_busy = rdy_lvl;
    for (int i = 0; i < TR; i++) begin
      @(negedge clk);
      t_nce[i] = nce_n; t_nre[i] = nre_n; t_nwe[i] = nwe_n; t_cle[i] = cle;
      t_ale[i] = ale; t_cap[i] = capture; t_done[i] = done; t_idle[i] = idle;
      if (i == 0) start = 1'b0;
      if (disturb) begin
        if (i == 1) timing_word = 26'h3FF_FFFF;
        if (i == 2) begin start = 1'b1; acc_type = rd ? 2'd1 : 2'd0; end
        if (i == 3) start = 1'b0;
      end
    end
    for (int i = 0; i < TR; i++) begin
      act   = (i >= g) && (i < fin);
      lowph = (i >= g + ce) && (i < g + ce + lo);
      e_nce[i]  = !act;
      e_nre[i]  = !(lowph && rd);
      e_nwe[i]  = !(lowph && !rd);
      e_cle[i]  = act && (ty == 2'd2);
      e_ale[i]  = act && (ty == 2'd3);
      e_cap[i]  = rd && (i == g + ce + lo);
      e_done[i] = (i == fin);
      e_idle[i] = !launch ? (i >= fin) : (rdy_lvl ? (i >= fin + bd + 1) : 1'b0);
    end
    chk(req, "nce_n (R3/R8)", t_nce, e_nce);
    chk(req, "nre_n (R2/R4/R12)", t_nre, e_nre);
    chk(req, "nwe_n (R2/R4/R12)", t_nwe, e_nwe);
    chk(req, "cle (R2)", t_cle, e_cle);
    chk(req, "ale (R2)", t_ale, e_ale);
    chk(req, "capture (R6)", t_cap, e_cap);
    chk(req, "done (R7)", t_done, e_done);
    chk(req, "idle (R7/R9)", t_idle, e_idle);
    if (launch && !rdy_lvl) begin
      chk1(req, "idle while device busy R9", idle, 1'b0);
      rdy_busy = 1'b1;
      @(negedge clk);
      chk1(req, "idle one cycle after ready R9", idle, 1'b1);
    end
    op_launch = 1'b0; rdy_busy = 1'b1;
  endtask

  task automatic test_reset();
    chk1("R1", "reset nce_n", nce_n, 1'b1);
    chk1("R1", "reset strobes", nre_n & nwe_n, 1'b1);
    chk1("R1", "reset pulses/latches", capture | done | cle | ale, 1'b0);
    chk1("R1", "reset idle", idle, 1'b1);
  endtask

  task automatic test_write_first();   // R2 R3 R4, R8 no gap on first access
    run_access("R4 write", 2'd1, mk(3, 2, 5, 4, 3, 4, 2), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_cmd_same_dir();  // R2 cle, R8 no gap same direction
    run_access("R8 command", 2'd2, mk(3, 2, 5, 4, 3, 4, 2), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_read_turn();     // R8 gap, R6 capture
    run_access("R6 read", 2'd0, mk(3, 2, 5, 4, 3, 4, 2), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_addr_turn();     // R2 ale, R8 gap
    run_access("R2 address", 2'd3, mk(3, 2, 5, 4, 3, 4, 2), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_zero_fields();   // R5 every field zero
    run_access("R5 zero word", 2'd0, mk(0, 0, 0, 0, 0, 0, 0), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_max_read();      // R4 R3 largest read strobe and setup
    run_access("R3 max read", 2'd0, mk(1, 1, 15, 15, 7, 2, 3), 1'b0, 1'b1, 1'b0);
  endtask
  task automatic test_disturb();       // R10 R11 late word change and extra start
    run_access("R11 R10 write", 2'd1, mk(2, 3, 4, 4, 2, 3, 1), 1'b0, 1'b1, 1'b1);
  endtask
  task automatic test_busy_ready();    // R9 ready line ignored during busy delay
    run_access("R9 busy ready", 2'd1, mk(1, 1, 1, 1, 1, 6, 1), 1'b1, 1'b1, 1'b0);
  endtask
  task automatic test_busy_wait();     // R9 waits for ready after delay
    run_access("R9 busy wait", 2'd1, mk(1, 1, 1, 1, 1, 6, 1), 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_write_first();
    test_cmd_same_dir();
    test_read_turn();
    test_addr_turn();
    test_zero_fields();
    test_max_read();
    test_disturb();
    test_busy_ready();
    test_busy_wait();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog R1..: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule